// File: doc/BRIEF.md
# Byte-Wide SPI Port with Master and Slave Modes

This block is a memory-mapped SPI peripheral for a small microcontroller. Software sees one shared 8-bit data register and one status register through a simple register port. A write to the data register loads the byte to transmit. In master mode that write also starts the transfer. The block then generates eight SCLK periods at a selectable rate. It shifts the byte out on MOSI, most significant bit first, and shifts a byte in from MISO. In slave mode SCLK and an active-low slave select come from outside. The block shifts its loaded byte out on MISO and takes in a byte from MOSI.

Static configuration inputs select the mode, the clock polarity, the clock phase, a two-bit rate code and the interrupt enable. When a byte completes, the received byte replaces the contents of the data register and a sticky done flag is set. An interrupt request is raised while the flag is set and interrupts are enabled. In slave mode the external SCLK, select and MOSI pass through synchronizers, and edges are detected in the system clock domain. For that reason the external SCLK must run at no more than a quarter of the system clock rate.

The control state machine has four states:
- IDLE: waiting.
- MSHIFT: a master transfer is running.
- SACTIVE: a slave byte is in progress.
- SWAIT: a slave byte is done and the port waits for the select to rise.

The transitions are:
- IDLE to MSHIFT on a data write in master mode.
- IDLE to SACTIVE when the synchronized select is low in slave mode.
- MSHIFT to IDLE after the sixteenth SCLK edge.
- SACTIVE to SWAIT on the eighth sampling edge when CPHA=1.
- SACTIVE to IDLE when the select rises. This counts as completion if CPHA=0 and eight bits have arrived, and as an abort otherwise.
- SWAIT to IDLE when the select rises.

Top module: `spi_byte_port`

## Requirements
- R1: After reset the data register reads 0x00, the status register reads 0, irq is low, and while no transfer runs SCLK rests at the level of cfg_cpol.
- R2: The data register is at address 0xF7. The status register is at 0xF6, with bit 0 the done flag and bit 1 busy. Every other address reads 0. Busy reads 1 while a transfer is in progress.
- R3: In master mode a write to the data register while idle starts a transfer that produces exactly 16 SCLK edges (eight periods) and returns SCLK to the idle level.
- R4: In master mode the written byte leaves on mosi_o MSB first, and the byte sampled from miso_i (MSB first) ends up in the data register, in all four CPOL/CPHA combinations. With CPHA=0 data is sampled on the first edge of each bit period, and with CPHA=1 on the second.
- R5: The rate code r gives an SCLK half period of 2^r system clocks (codes 0..3 divide by 2, 4, 8, 16). A master transfer therefore keeps busy high for 16·2^r cycles.
- R6: A write to the data register while a master transfer is running is ignored. It changes neither the bits sent nor the final data register value.
- R7: In slave mode the loaded byte leaves on miso_o MSB first and the byte on mosi_i is received MSB first, in all four modes, for an external SCLK of at most a quarter of the system clock.
- R8: In slave mode with CPHA=1 the byte completes on the eighth sampling edge while select is still low.
- R9: In slave mode with CPHA=0 the data register and flag do not change until select returns high after eight bits. They are updated then.
- R10: In slave mode, if select rises before eight bits have been received, the flag stays clear and the data register keeps its value.
- R11: Completion sets the done flag, which stays set until software writes the status register with bit 0 equal to 0. Writing bit 0 as 1 has no effect. irq equals flag AND cfg_irq_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0 = sample on first edge, 1 = sample on second edge |
| cfg_rate | input | 2 | Master SCLK rate code |
| cfg_irq_en | input | 1 | Interrupt enable |
| sclk_o | output | 1 | SCLK driven in master mode |
| sclk_i | input | 1 | SCLK received in slave mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle:
- SCLK sits at the polarity level whenever the machine is idle.
- The data register cannot move during a master transfer.
- The done flag never falls without a clearing write, rises only at the end of a transfer, and irq never appears without it.
- The slave output bit holds while idle.

Only the bench scenarios can show the byte-level behaviour:
- The bit order on both pins in all four modes.
- The exact edge count and the rate-dependent duration.
- The different completion points of the two slave phases.
- The abort on an early select release.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MSHIFT  = 2'd1,
        ST_SACTIVE = 2'd2,
        ST_SWAIT   = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CW = (1 << RATE_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = CW'((1 << rate) - 1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= RST_VAL;
            end else if (g == 0) begin
                chain[g] <= d;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_port_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter int          RATE_W      = 2,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned DATA_ADDR   = 32'hF7,
    parameter int unsigned STAT_ADDR   = 32'hF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_irq_en,
    output logic              sclk_o,
    input  logic              sclk_i,
    input  logic              ss_n_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic              miso_i,
    output logic              irq
);
    localparam int EDGES = 2 * DATA_W;
    localparam int CNT_W = $clog2(EDGES);

    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] tx_q, rx_q, data_q, rx_next, captured;
    logic              tog_q, flag_q, sclk_d;
    logic              sclk_s, ss_s, mosi_s;
    logic              tick, wr_data, wr_stat, load, start_m;
    logic              s_chg, s_lead, s_trail, m_lead, m_trail;
    logic              samp, shft, in_bit;
    logic              m_done, s_done1, s_done0, done, busy;

    // Slave pins into the system clock domain; select resets high.
    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk_i, ss_n_i, mosi_i}),
        .q    ({sclk_s, ss_s, mosi_s})
    );

    spi_rate_div #(.RATE_W(RATE_W)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_MSHIFT),
        .rate (cfg_rate),
        .tick (tick)
    );

    assign wr_data = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));
    assign load    = wr_data && (state_q == ST_IDLE);
    assign start_m = load && cfg_master;

    // Leading edge leaves the idle level, trailing edge returns to it.
    assign s_chg   = sclk_s != sclk_d;
    assign s_lead  = s_chg && (sclk_d == cfg_cpol);
    assign s_trail = s_chg && (sclk_d != cfg_cpol);
    assign m_lead  = tick && !cnt_q[0];
    assign m_trail = tick && cnt_q[0];

    always_comb begin
        samp   = 1'b0;
        shft   = 1'b0;
        in_bit = miso_i;
        unique case (state_q)
            ST_MSHIFT: begin
                samp = cfg_cpha ? m_trail : m_lead;
                shft = cfg_cpha ? (m_lead && cnt_q != '0) : m_trail;
            end
            ST_SACTIVE: begin
                in_bit = mosi_s;
                samp   = (cnt_q < CNT_W'(DATA_W)) && (cfg_cpha ? s_trail : s_lead);
                shft   = cfg_cpha ? (s_lead && cnt_q != '0) : s_trail;
            end
            default: ;
        endcase
    end

    assign rx_next  = {rx_q[DATA_W-2:0], in_bit};
    assign captured = samp ? rx_next : rx_q;
    assign m_done   = (state_q == ST_MSHIFT) && tick && (cnt_q == CNT_W'(EDGES-1));
    assign s_done1  = (state_q == ST_SACTIVE) && cfg_cpha && samp
                      && (cnt_q == CNT_W'(DATA_W-1));
    assign s_done0  = (state_q == ST_SACTIVE) && !cfg_cpha && ss_s
                      && (cnt_q == CNT_W'(DATA_W));
    assign done     = m_done || s_done1 || s_done0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_m)                  state_d = ST_MSHIFT;
                else if (!cfg_master && !ss_s) state_d = ST_SACTIVE;
            end
            ST_MSHIFT:  if (m_done)  state_d = ST_IDLE;
            ST_SACTIVE: begin
                if (s_done1)   state_d = ST_SWAIT;
                else if (ss_s) state_d = ST_IDLE;
            end
            ST_SWAIT:   if (ss_s)    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            data_q <= '0;
            tog_q  <= 1'b0;
            flag_q <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (state_q == ST_IDLE)                 cnt_q <= '0;
            else if (state_q == ST_MSHIFT && tick)  cnt_q <= cnt_q + 1'b1;
            else if (state_q == ST_SACTIVE && samp) cnt_q <= cnt_q + 1'b1;

            if (state_q == ST_MSHIFT && tick) tog_q <= !tog_q;

            if (load)      tx_q <= bus_wdata;
            else if (shft) tx_q <= {tx_q[DATA_W-2:0], 1'b0};

            if (samp) rx_q <= rx_next;

            if (load)      data_q <= bus_wdata;
            else if (done) data_q <= captured;

            if (done)                           flag_q <= 1'b1;
            else if (wr_stat && !bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        busy   = state_q != ST_IDLE;
        sclk_o = cfg_cpol ^ tog_q;
        mosi_o = tx_q[DATA_W-1];
        miso_o = tx_q[DATA_W-1];
        irq    = flag_q && cfg_irq_en;
        if (bus_addr == ADDR_W'(DATA_ADDR))      bus_rdata = data_q;
        else if (bus_addr == ADDR_W'(STAT_ADDR)) bus_rdata = {{(DATA_W-2){1'b0}}, busy, flag_q};
        else                                     bus_rdata = '0;
    end
endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk
    import spi_port_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int unsigned DATA_ADDR = 32'hF7,
    parameter int unsigned STAT_ADDR = 32'hF6
) (
    input logic              clk,
    input logic              rst_n,
    input xfer_state_e       state_q,
    input logic              flag_q,
    input logic [DATA_W-1:0] data_q,
    input logic              irq,
    input logic              sclk_o,
    input logic              miso_o,
    input logic              cfg_cpol,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    logic clr_wr, data_wr;
    assign clr_wr  = bus_wr && bus_addr == ADDR_W'(STAT_ADDR) && !bus_wdata[0];
    assign data_wr = bus_wr && bus_addr == ADDR_W'(DATA_ADDR);

    a_r1_idle_clk_level: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> sclk_o == cfg_cpol);

    a_r6_data_frozen_in_master: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MSHIFT && $past(state_q) == ST_MSHIFT) |-> $stable(data_q));

    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr) |=> flag_q);

    a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    a_r11_flag_rise_from_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(state_q) != ST_IDLE);

    a_r7_miso_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !data_wr) |=> $stable(miso_o));
endmodule

bind spi_byte_port spi_byte_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)
) i_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .flag_q(flag_q), .data_q(data_q),
    .irq(irq), .sclk_o(sclk_o), .miso_o(miso_o), .cfg_cpol(cfg_cpol),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_spi_byte_port.sv
module test_spi_byte_port;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;
    localparam logic [7:0] A_DATA = 8'hF7;
    localparam logic [7:0] A_STAT = 8'hF6;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0;
    logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
    logic cfg_master = 1, cfg_cpol = 0, cfg_cpha = 0, cfg_irq_en = 0;
    logic [1:0] cfg_rate = 0;
    logic sclk_o, sclk_i = 0, ss_n_i = 1, mosi_o, mosi_i = 0, miso_o, miso_i = 0, irq;
    int n_checks = 0, n_errors = 0;

    spi_byte_port i_spi_byte_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate),
        .cfg_irq_en(cfg_irq_en), .sclk_o(sclk_o), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
        .mosi_o(mosi_o), .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_cycles(logic [1:0] r);
        return 16 << r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic run_master(bit cpol, bit cpha, logic [1:0] rate,
                              logic [7:0] tx, logic [7:0] sl, bit poke);
        int n = 0, edges = 0, lead = 0, trail = 0;
        logic [7:0] cap = 0, v;
        logic prev;
        @(negedge clk);
        cfg_master = 1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_rate = rate; miso_i = sl[7];
        @(negedge clk);
        prev = sclk_o;
        check("R1 idle sclk level", sclk_o, cpol);
        bus_write(A_DATA, tx);
        bus_addr = A_STAT;
        while (n < 4000) begin
            if (sclk_o != prev) begin
                prev = sclk_o; edges++;
                if (sclk_o != cpol) begin
                    if (cpha) miso_i = sl[3'(7-lead)]; else cap = {cap[6:0], mosi_o};
                    lead++;
                end else begin
                    if (cpha) cap = {cap[6:0], mosi_o};
                    else begin trail++; if (trail < 8) miso_i = sl[3'(7-trail)]; end
                end
            end
            if (poke && n == 3) begin
                bus_wr = 1; bus_addr = A_DATA; bus_wdata = ~tx;
            end else begin
                bus_wr = 0; bus_addr = A_STAT;
                #1;
                if (!bus_rdata[1]) break;
                if (n == 1) check("R2 busy bit in status", bus_rdata[1:0], 2'b10);
            end
            n++;
            @(negedge clk);
        end
        check("R3 sixteen sclk edges", edges, 16);
        check("R3 sclk back at idle", sclk_o, cpol);
        check("R4 mosi byte msb first", cap, tx);
        if (!poke) check("R5 transfer length", n, exp_cycles(rate));
        bus_read(A_DATA, v);
        if (poke) check("R6 write during transfer ignored", v, sl);
        else      check("R4 received miso byte", v, sl);
        bus_read(A_STAT, v);
        check("R11 flag set after master byte", v, 8'h01);
        bus_write(A_STAT, 8'h00);
    endtask

    task automatic run_slave(bit cpol, bit cpha, logic [7:0] tx, logic [7:0] rx, int nbits);
        logic [7:0] got = 0, v;
        @(negedge clk);
        cfg_master = 0; cfg_cpol = cpol; cfg_cpha = cpha; sclk_i = cpol; ss_n_i = 1; mosi_i = 0;
        repeat (4) @(negedge clk);
        bus_write(A_DATA, tx);
        if (!cpha) mosi_i = rx[7];
        ss_n_i = 0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (cpha) mosi_i = rx[3'(7-i)]; else got = {got[6:0], miso_o};
            sclk_i = ~cpol;
            repeat (H) @(negedge clk);
            if (cpha) got = {got[6:0], miso_o};
            sclk_i = cpol;
            if (!cpha && i < 7) mosi_i = rx[3'(6-i)];
            repeat (H) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        if (nbits < 8) begin
            ss_n_i = 1;
            repeat (6) @(negedge clk);
            bus_read(A_STAT, v);
            check("R10 no flag on early release", v, 8'h00);
            bus_read(A_DATA, v);
            check("R10 data kept on early release", v, tx);
        end else begin
            check("R7 miso byte msb first", got, tx);
            if (cpha) begin
                bus_read(A_STAT, v);
                check("R8 done while select low", v, 8'h03);
                bus_read(A_DATA, v);
                check("R8 received mosi byte", v, rx);
                ss_n_i = 1;
            end else begin
                bus_read(A_STAT, v);
                check("R9 no flag before select rise", v, 8'h02);
                bus_read(A_DATA, v);
                check("R9 data unchanged before select rise", v, tx);
                ss_n_i = 1;
                repeat (6) @(negedge clk);
                bus_read(A_DATA, v);
                check("R9 received mosi byte", v, rx);
            end
            repeat (6) @(negedge clk);
            bus_read(A_STAT, v);
            check("R7 flag set and idle after slave byte", v, 8'h01);
        end
        bus_write(A_STAT, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_errors + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        bus_read(A_DATA, v);  check("R1 data reset value", v, 8'h00);
        bus_read(A_STAT, v);  check("R1 status reset value", v, 8'h00);
        check("R1 irq low", irq, 1'b0);
        check("R1 sclk at cpol", sclk_o, 1'b0);
        cfg_cpol = 1;
        @(negedge clk);
        check("R1 sclk follows cpol", sclk_o, 1'b1);
        bus_read(8'h00, v);   check("R2 unmapped address reads 0", v, 8'h00);

        run_master(0, 0, 2'd0, 8'hA5, 8'h3C, 0);
        run_master(1, 1, 2'd3, 8'h81, 8'h7E, 0);
        run_master(0, 1, 2'd1, 8'h5A, 8'hC3, 1);

        // Flag and interrupt behaviour (R11)
        cfg_irq_en = 0;
        cfg_master = 1;
        bus_write(A_DATA, 8'h11);
        repeat (40) @(negedge clk);
        check("R11 irq masked when disabled", irq, 1'b0);
        cfg_irq_en = 1;
        @(negedge clk);
        check("R11 irq with flag and enable", irq, 1'b1);
        bus_write(A_STAT, 8'h01);
        bus_read(A_STAT, v);
        check("R11 writing 1 keeps flag", v, 8'h01);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, v);
        check("R11 writing 0 clears flag", v, 8'h00);
        check("R11 irq drops after clear", irq, 1'b0);
        cfg_irq_en = 0;

        for (int k = 0; k < 16; k++) begin
            run_master(1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 0);
        end

        run_slave(0, 0, 8'h96, 8'h1E, 8);
        run_slave(1, 1, 8'hF0, 8'h0F, 8);
        run_slave(0, 1, 8'h3C, 8'hA7, 8);
        run_slave(1, 0, 8'hC5, 8'h6B, 8);
        run_slave(0, 0, 8'h55, 8'hFF, 5);
        run_slave(1, 1, 8'hAA, 8'h00, 3);
        for (int k = 0; k < 10; k++) begin
            run_slave(1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule